// File: doc/BRIEF.md
# Register Bypass and Load-Use Stall Control

This block decides, every cycle, how the operands of an in-order five-stage integer pipeline (fetch, decode, execute, memory, writeback) are sourced when an instruction depends on a result that has not yet reached the register file. It looks at the source registers of the instructions in decode, execute and memory, and at the destination, write-enable and load flags of the older instructions in execute, memory and writeback. It is purely combinational.

It produces one bypass select for each of the two execute-stage ALU operands, a one-bit select for the store-data path in the memory stage, a hold signal that freezes the PC and the fetch/decode register, and a bubble signal that turns the execute-stage control into a no-op. A store whose data register is written by the load directly ahead of it does not stall: the loaded value is handed from the writeback register straight into the store's memory stage. A store whose base register comes from that load still stalls for one cycle. Write-after-write and write-after-read pairs cause no action, and because the register file returns a value written in the same cycle, an instruction three slots behind a producer needs no bypass.

Top module: `hz_unit`

## Requirements
- R1: `fwd_a`/`fwd_b` equal 2'b10 (take the execute/memory register) when the memory-stage instruction writes (`mem_we`=1), is not a load, and its nonzero destination equals the execute-stage source.
- R2: `fwd_a`/`fwd_b` equal 2'b01 (take the memory/writeback register) when the writeback-stage instruction writes a nonzero destination equal to the execute-stage source and R1 does not apply; otherwise they equal 2'b00 (register file).
- R3: When both the memory-stage and the writeback-stage instruction qualify for the same source, the memory-stage result (2'b10) wins.
- R4: A source or destination of register 0, or a producer whose write-enable is low, never causes a forward, a store-data bypass or a stall.
- R5: When the execute-stage instruction is a writing load whose nonzero destination equals decode's `id_src_a`, or equals `id_src_b` of a non-store, `hold` and `bubble` are both 1; otherwise both are 0.
- R6: A decode-stage store (`id_store`=1) whose only match with the load in execute is its data register (`id_src_b`) does not stall.
- R7: A decode-stage store whose base register (`id_src_a`) equals the destination of the load in execute stalls.
- R8: `fwd_st` is 1 exactly when the memory-stage instruction is a store, the writeback-stage instruction is a writing load, and its nonzero destination equals the store's data register `mem_src_d`.
- R9: A non-load in execute never stalls, and the writeback-stage destination has no influence on `hold` (no hazard is reported at a distance of three).
- R10: The encoding 2'b11 never appears on `fwd_a` or `fwd_b`, and a load in the memory stage is never chosen as a 2'b10 source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | RW | Decode-stage first source (base register for a store) |
| id_src_b | input | RW | Decode-stage second source (data register for a store) |
| id_store | input | 1 | Decode-stage instruction is a store |
| ex_src_a | input | RW | Execute-stage first ALU source |
| ex_src_b | input | RW | Execute-stage second ALU source |
| ex_rd | input | RW | Execute-stage destination |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | RW | Memory-stage destination |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_src_d | input | RW | Memory-stage store data register |
| wb_rd | input | RW | Writeback-stage destination |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| wb_load | input | 1 | Writeback-stage instruction is a load |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 writeback, 10 memory |
| fwd_b | output | 2 | Operand B select, same encoding |
| fwd_st | output | 1 | Store data: 0 pipeline value, 1 writeback value |
| hold | output | 1 | Freeze PC and fetch/decode register |
| bubble | output | 1 | Clear execute-stage control to a no-op |

## Verification
The checks take for granted that the stage flags are mutually sensible: a load always has its write-enable set, a store never does, and a load and a store are never flagged in the same stage. The random stimulus derives the write-enable from the instruction kind it picks so these combinations never arise, and draws register numbers from a handful of values including 0 so that matches, double matches and register-0 cases all occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam int unsigned N_OPS  = 2;
endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
  import hz_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    sel
);
  logic src_live;
  logic hit_mem;
  logic hit_wb;

  always_comb begin
    src_live = (src != '0);
    // a load in memory has no data yet; it never feeds execute directly
    hit_mem  = src_live && mem_we && !mem_load && (mem_rd == src);
    hit_wb   = src_live && wb_we && (wb_rd == src);
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic          id_store,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  output logic          need_hold
);
  logic load_live;
  logic hit_a;
  logic hit_b;

  always_comb begin
    load_live = ex_load && ex_we && (ex_rd != '0);
    hit_a     = (id_src_a == ex_rd);
    // store data is consumed one stage later and bypassed there
    hit_b     = (id_src_b == ex_rd) && !id_store;
    need_hold = load_live && (hit_a || hit_b);
  end
endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd #(
  parameter int unsigned RW = 5
) (
  input  logic          mem_store,
  input  logic [RW-1:0] mem_src_d,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          wb_load,
  output logic          st_sel
);
  always_comb begin
    st_sel = mem_store && wb_load && wb_we && (wb_rd != '0) && (wb_rd == mem_src_d);
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic          id_store,
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic          mem_store,
  input  logic [RW-1:0] mem_src_d,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic          wb_load,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          fwd_st,
  output logic          hold,
  output logic          bubble
);
  logic [N_OPS-1:0][RW-1:0] ex_src;
  logic [N_OPS-1:0][1:0]    op_sel;
  logic                     lu_hold;

  assign ex_src[0] = ex_src_a;
  assign ex_src[1] = ex_src_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hz_operand_sel #(.RW(RW)) u_sel (
      .src      (ex_src[g]),
      .mem_rd   (mem_rd),
      .mem_we   (mem_we),
      .mem_load (mem_load),
      .wb_rd    (wb_rd),
      .wb_we    (wb_we),
      .sel      (op_sel[g])
    );
  end

  hz_load_use #(.RW(RW)) u_lu (
    .id_src_a  (id_src_a),
    .id_src_b  (id_src_b),
    .id_store  (id_store),
    .ex_rd     (ex_rd),
    .ex_we     (ex_we),
    .ex_load   (ex_load),
    .need_hold (lu_hold)
  );

  hz_store_fwd #(.RW(RW)) u_st (
    .mem_store (mem_store),
    .mem_src_d (mem_src_d),
    .wb_rd     (wb_rd),
    .wb_we     (wb_we),
    .wb_load   (wb_load),
    .st_sel    (fwd_st)
  );

  assign fwd_a  = op_sel[0];
  assign fwd_b  = op_sel[1];
  assign hold   = lu_hold;
  assign bubble = lu_hold;
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int unsigned RW = 5
) (
  input logic [RW-1:0] id_src_a,
  input logic [RW-1:0] id_src_b,
  input logic          id_store,
  input logic [RW-1:0] ex_src_a,
  input logic [RW-1:0] ex_rd,
  input logic          ex_load,
  input logic [RW-1:0] mem_rd,
  input logic          mem_load,
  input logic          mem_store,
  input logic [RW-1:0] wb_rd,
  input logic          wb_load,
  input logic          wb_we,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          fwd_st,
  input logic          hold,
  input logic          bubble
);
  always_comb begin
    p_no_code11_r10: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    p_mem_sel_match_r1: assert (fwd_a != 2'b10 || (mem_rd == ex_src_a && !mem_load));
    p_zero_src_r4: assert (ex_src_a != '0 || fwd_a == 2'b00);
    p_hold_needs_load_r9: assert (!hold || ex_load);
    p_hold_bubble_r5: assert (hold == bubble);
    p_store_data_nostall_r6: assert (!(id_store && id_src_b == ex_rd && id_src_a != ex_rd) || !hold);
    p_stfwd_from_load_r8: assert (!fwd_st || (wb_load && wb_we && mem_store && wb_rd != '0));
    p_wb_sel_match_r2: assert (fwd_a != 2'b01 || wb_rd == ex_src_a);
  end
endmodule

bind hz_unit hz_unit_chk #(.RW(RW)) u_chk (
  .id_src_a  (id_src_a),
  .id_src_b  (id_src_b),
  .id_store  (id_store),
  .ex_src_a  (ex_src_a),
  .ex_rd     (ex_rd),
  .ex_load   (ex_load),
  .mem_rd    (mem_rd),
  .mem_load  (mem_load),
  .mem_store (mem_store),
  .wb_rd     (wb_rd),
  .wb_load   (wb_load),
  .wb_we     (wb_we),
  .fwd_a     (fwd_a),
  .fwd_b     (fwd_b),
  .fwd_st    (fwd_st),
  .hold      (hold),
  .bubble    (bubble)
);

// File: tb/sim_hz_unit.sv
`timescale 1ns/1ps
module sim_hz_unit;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [RW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_rd, mem_rd, mem_src_d, wb_rd;
  logic id_store, ex_we, ex_load, mem_we, mem_load, mem_store, wb_we, wb_load;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_st, hold, bubble;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  hz_unit #(.RW(RW)) u0 (.*);

  function automatic logic [1:0] exp_sel(logic [RW-1:0] s);
    if (s != 0 && mem_we && !mem_load && mem_rd == s) return 2'b10;
    if (s != 0 && wb_we && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_hold();
    if (!(ex_load && ex_we && ex_rd != 0)) return 1'b0;
    return (id_src_a == ex_rd) || (!id_store && id_src_b == ex_rd);
  endfunction

  function automatic logic exp_st();
    return mem_store && wb_load && wb_we && wb_rd != 0 && wb_rd == mem_src_d;
  endfunction

  function automatic string sel_tag(logic [1:0] e);
    return (e == 2'b10) ? "R1" : (e == 2'b01) ? "R2" : "R4";
  endfunction

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    logic [1:0] ea, eb;
    ea = exp_sel(ex_src_a);
    eb = exp_sel(ex_src_b);
    chk({ctx, " fwd_a ", sel_tag(ea)}, {1'b0, fwd_a}, {1'b0, ea});
    chk({ctx, " fwd_b ", sel_tag(eb)}, {1'b0, fwd_b}, {1'b0, eb});
    chk({ctx, " fwd_st R8"}, {2'b0, fwd_st}, {2'b0, exp_st()});
    chk({ctx, " hold R5"}, {2'b0, hold}, {2'b0, exp_hold()});
    chk({ctx, " bubble R5"}, {2'b0, bubble}, {2'b0, exp_hold()});
  endtask

  task automatic idle();
    {id_src_a, id_src_b, ex_src_a, ex_src_b, ex_rd, mem_rd, mem_src_d, wb_rd} = '0;
    {id_store, ex_we, ex_load, mem_we, mem_load, mem_store, wb_we, wb_load} = '0;
  endtask

  // kind: 0 alu, 1 load, 2 store, 3 nop
  task automatic rand_stage(output logic [RW-1:0] rd, output logic we,
                            output logic ld, output logic st);
    int k;
    k  = $urandom_range(0, 3);
    rd = RW'($urandom_range(0, 3));
    ld = (k == 1);
    st = (k == 2);
    we = (k <= 1);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic dummy;
    void'($urandom(32'h1234_5678));
    idle();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    step();
    check_all("reset idle R4");

    // R3: both producers match, memory result wins
    @(posedge clk); idle();
    ex_src_a = 5'd7; mem_rd = 5'd7; mem_we = 1; wb_rd = 5'd7; wb_we = 1;
    step(); chk("R3 priority", {1'b0, fwd_a}, 3'b010);

    // R4: register 0 never forwards, we low never forwards
    @(posedge clk); idle();
    ex_src_a = 0; mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
    ex_src_b = 5'd9; wb_rd = 0; mem_rd = 0;
    step(); chk("R4 zero reg", {1'b0, fwd_a}, 3'b000);
    @(posedge clk); idle();
    ex_src_b = 5'd9; mem_rd = 5'd9; mem_we = 0;
    step(); chk("R4 we low", {1'b0, fwd_b}, 3'b000);

    // R10: memory load matching plus writeback match falls back to 01
    @(posedge clk); idle();
    ex_src_a = 5'd4; mem_rd = 5'd4; mem_we = 1; mem_load = 1; wb_rd = 5'd4; wb_we = 1;
    step(); chk("R10 load in mem", {1'b0, fwd_a}, 3'b001);

    // R5: load-use on an ALU consumer
    @(posedge clk); idle();
    ex_rd = 5'd6; ex_we = 1; ex_load = 1; id_src_b = 5'd6;
    step(); chk("R5 hold", {2'b0, hold}, 3'b001); chk("R5 bubble", {2'b0, bubble}, 3'b001);

    // R6: store data from load, no stall
    @(posedge clk); id_store = 1;
    step(); chk("R6 store data", {2'b0, hold}, 3'b000);

    // R7: store base from load, stall
    @(posedge clk); id_src_a = 5'd6; id_src_b = 5'd2;
    step(); chk("R7 store base", {2'b0, hold}, 3'b001);

    // R9: non-load producer in execute and a writeback match never stall
    @(posedge clk); idle();
    ex_rd = 5'd6; ex_we = 1; id_src_a = 5'd6; wb_rd = 5'd6; wb_we = 1; wb_load = 1;
    step(); chk("R9 no stall", {2'b0, hold}, 3'b000);

    // R8: memory-to-memory store data bypass
    @(posedge clk); idle();
    mem_store = 1; mem_src_d = 5'd5; wb_rd = 5'd5; wb_we = 1; wb_load = 1;
    step(); chk("R8 store bypass", {2'b0, fwd_st}, 3'b001);
    @(posedge clk); wb_load = 0;
    step(); chk("R8 alu in wb", {2'b0, fwd_st}, 3'b000);

    // random mixes
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      id_src_a  = RW'($urandom_range(0, 3));
      id_src_b  = RW'($urandom_range(0, 3));
      id_store  = 1'($urandom_range(0, 1));
      ex_src_a  = RW'($urandom_range(0, 3));
      ex_src_b  = RW'($urandom_range(0, 3));
      mem_src_d = RW'($urandom_range(0, 3));
      rand_stage(ex_rd, ex_we, ex_load, dummy);
      rand_stage(mem_rd, mem_we, mem_load, mem_store);
      rand_stage(wb_rd, wb_we, wb_load, dummy);
      step();
      check_all("random");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule